// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes one bit per serial clock pulse, least significant bit first. A holding register sits in front of a shift register, so two bytes can be in flight at once. Software polls an empty flag, writes the next byte into the holding register, and then clears the flag. The block moves that byte into the shift register as soon as the shifter is free, or on the final rising clock edge of the current byte. Each move sets the empty flag again. This is how bytes go out back to back with no gap.

The serial clock comes from one of two sources. It can be produced internally from the system clock by a programmable divider. It can also be taken from an external pin, after a synchronizer and an edge detector. With the internal source, the data line changes on the falling clock edge and a receiver samples on the rising edge. When the holding register is empty at the end of a byte, the internal clock stops high. In either mode the data line keeps the last bit sent. A level interrupt request is raised while the buffer is empty and interrupts are enabled.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset the empty flag is 1, the interrupt request is 0, the internal serial clock is 1, and both output enables (data and clock) are 0.
- R2: A clear request while the empty flag is 1 drops the flag to 0 on the next clock. A clear request while the flag is already 0 has no effect: exactly one byte is sent for that buffer load.
- R3: When the holding register is moved into the shift register, the empty flag returns to 1. From idle, the flag returns to 1 on the clock after the clear.
- R4: Each byte is sent as 8 bits, bit 0 first. Every bit is valid at the rising edge of the serial clock.
- R5: With the internal source (mode select 0), the data line changes only on a falling edge of the clock output. The low phase lasts div+1 system clock cycles.
- R6: With the internal source, every half period within a burst lasts div+1 cycles. This includes the high phase between the last bit of one byte and the first bit of a byte that was queued in time.
- R7: With the internal source, when a byte ends and the buffer is empty, the clock output stays at 1 with no further pulses, and the data line holds the last bit sent.
- R8: With the external source (mode select 1), the clock output enable is 0 and the internal clock stays at 1. The data line advances only on a synchronized falling edge of the clock input.
- R9: With the external source, clock pulses that arrive after a byte has finished, while the buffer is empty, leave the data line at the last bit sent.
- R10: The interrupt request equals the empty flag ANDed with the interrupt enable of the previous cycle.
- R11: The data output enable follows the transmit enable one cycle later. No byte is moved into the shift register while the transmit enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; drives the data pin and allows loads |
| irq_en | input | 1 | Transmit interrupt enable |
| ext_clk_sel | input | 1 | 0: internal divider clock, 1: external clock input |
| baud_div | input | DIV_W | Half period of the internal clock minus one, in system cycles |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to be written into the holding register |
| clr_empty | input | 1 | Software clear request for the empty flag |
| empty_flag | output | 1 | Holding register empty |
| tx_irq | output | 1 | Transmit interrupt request (level) |
| sck_in | input | 1 | Serial clock pin input |
| sck_out | output | 1 | Serial clock pin output value |
| sck_oe | output | 1 | Serial clock pin output enable |
| sdo | output | 1 | Serial data pin output value |
| sdo_oe | output | 1 | Serial data pin output enable |

## Verification
The assertions assume three things about the inputs. The clock mode select and the divider change only while no byte is in the shift register. External clock half periods are long compared with the three-cycle path through the synchronizer and edge detector. An external falling edge never lands in the same cycle as a load from idle. The stimulus switches mode and divider only after the expected-bit queue has drained and the line has settled. It drives the external clock with eight-cycle half periods, and it waits several cycles after each clear before the first external pulse.

// File: rtl/sst_pkg.sv
package sst_pkg;
  // Edge events that advance the shifter, one cycle wide each.
  typedef struct packed {
    logic fall;
    logic rise;
  } sst_edge_t;
endpackage

// File: rtl/sst_int_clkgen.sv
module sst_int_clkgen
  import sst_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output sst_edge_t        evt
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             tick;

  assign tick     = run && (cnt_q == '0);
  assign evt.fall = tick && sck_q;
  assign evt.rise = tick && !sck_q;
  assign sck      = sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!run) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      sck_q <= ~sck_q;
      cnt_q <= div;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sst_ext_sync.sv
module sst_ext_sync
  import sst_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin,
  output sst_edge_t evt
);
  localparam int unsigned LAST = SYNC_STAGES;

  // chain[SYNC_STAGES-1] is the synchronized value, chain[LAST] its delayed copy
  logic [LAST:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[LAST-1:0], pin};
  end

  assign evt.fall = chain_q[LAST] && !chain_q[LAST-1];
  assign evt.rise = !chain_q[LAST] && chain_q[LAST-1];
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  sst_edge_t         evt,
  output logic              busy,
  output logic              done,
  output logic              sdo
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  sent_q;
  logic              busy_q;
  logic              sdo_q;

  assign done = busy_q && evt.rise && (sent_q == FULL);
  assign busy = busy_q;
  assign sdo  = sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      sent_q  <= '0;
      busy_q  <= 1'b0;
      sdo_q   <= 1'b1;
    end else if (load) begin
      shreg_q <= load_data;
      sent_q  <= '0;
      busy_q  <= 1'b1;
    end else if (done) begin
      busy_q  <= 1'b0;
    end else if (busy_q && evt.fall && (sent_q != FULL)) begin
      sdo_q   <= shreg_q[0];
      shreg_q <= shreg_q >> 1;
      sent_q  <= sent_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              irq_en,
  input  logic              ext_clk_sel,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_empty,
  output logic              empty_flag,
  output logic              tx_irq,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [DATA_W-1:0] hold_q;
  logic              empty_q;
  logic              empty_d;
  logic              irq_q;
  logic              sck_oe_q;
  logic              sdo_oe_q;
  logic              load;
  logic              busy;
  logic              done;
  sst_edge_t         int_evt;
  sst_edge_t         ext_evt;
  sst_edge_t         evt;

  sst_int_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk (clk),
    .rst (rst),
    .run (busy && !ext_clk_sel),
    .div (baud_div),
    .sck (sck_out),
    .evt (int_evt)
  );

  sst_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .pin (sck_in),
    .evt (ext_evt)
  );

  assign evt = ext_clk_sel ? ext_evt : int_evt;

  sst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (hold_q),
    .evt       (evt),
    .busy      (busy),
    .done      (done),
    .sdo       (sdo)
  );

  // A byte moves over when the flag has been cleared and the shifter is free or finishing.
  assign load = tx_en && !empty_q && (!busy || done);

  always_comb begin
    empty_d = empty_q;
    if (load)                      empty_d = 1'b1;
    else if (clr_empty && empty_q) empty_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      empty_q  <= 1'b1;
      irq_q    <= 1'b0;
      sck_oe_q <= 1'b0;
      sdo_oe_q <= 1'b0;
    end else begin
      if (wr_en) hold_q <= wr_data;
      empty_q  <= empty_d;
      irq_q    <= empty_d && irq_en;
      sck_oe_q <= tx_en && !ext_clk_sel;
      sdo_oe_q <= tx_en;
    end
  end

  assign empty_flag = empty_q;
  assign tx_irq     = irq_q;
  assign sck_oe     = sck_oe_q;
  assign sdo_oe     = sdo_oe_q;
endmodule

// File: rtl/sync_ser_tx_checker.sv
module sync_ser_tx_checker (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic irq_en,
  input logic ext_clk_sel,
  input logic clr_empty,
  input logic empty_flag,
  input logic tx_irq,
  input logic sck_out,
  input logic sdo
);
  assert_clear_needs_request_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(empty_flag) |-> $past(clr_empty));

  assert_load_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(empty_flag) |-> $past(tx_en));

  assert_sdo_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (!ext_clk_sel && !$past(ext_clk_sel) && (sdo != $past(sdo))) |-> (!sck_out && $past(sck_out)));

  assert_irq_needs_empty_R10: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> empty_flag);

  assert_irq_follows_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (empty_flag && $past(irq_en)) |-> tx_irq);

  assert_int_clock_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (ext_clk_sel && $past(ext_clk_sel)) |-> sck_out);
endmodule

bind sync_ser_tx sync_ser_tx_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_en       (tx_en),
  .irq_en      (irq_en),
  .ext_clk_sel (ext_clk_sel),
  .clr_empty   (clr_empty),
  .empty_flag  (empty_flag),
  .tx_irq      (tx_irq),
  .sck_out     (sck_out),
  .sdo         (sdo)
);

// File: tb/sync_ser_tx_bench.sv
module sync_ser_tx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       irq_en = 1'b0;
  logic       ext_clk_sel = 1'b0;
  logic [7:0] baud_div = 8'd2;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       clr_empty = 1'b0;
  logic       sck_in = 1'b1;
  logic       empty_flag, tx_irq, sck_out, sck_oe, sdo, sdo_oe;

  int   errors = 0;
  int   checks = 0;
  int   cyc = 0;
  logic exp_q [$];
  logic prev_mon = 1'b1;
  logic last_bit = 1'b1;
  logic b2b = 1'b0;
  logic have_rise = 1'b0;
  logic have_fall = 1'b0;
  int   last_rise = 0;
  int   last_fall = 0;

  always #2 clk = ~clk;

  sync_ser_tx u_sync_ser_tx (
    .clk, .rst, .tx_en, .irq_en, .ext_clk_sel, .baud_div, .wr_en, .wr_data,
    .clr_empty, .empty_flag, .tx_irq, .sck_in, .sck_out, .sck_oe, .sdo, .sdo_oe
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected bits at each rising serial clock edge.
  always @(negedge clk) begin
    if (!rst) begin
      logic mon;
      mon = ext_clk_sel ? sck_in : sck_out;
      if (mon && !prev_mon) begin
        if (!ext_clk_sel && have_fall) chk("R5 low phase length", cyc - last_fall, baud_div + 1);
        if (exp_q.size() > 0) begin
          logic e;
          e = exp_q.pop_front();
          chk("R4 serial bit", sdo, e);
          last_bit = e;
        end else if (ext_clk_sel) begin
          chk("R9 data held on extra pulse", sdo, last_bit);
        end else begin
          checks++;
          errors++;
          $display("FAIL R7: actual=unexpected clock pulse expected=no pulse");
        end
        last_rise = cyc;
        have_rise = 1'b1;
      end
      if (!mon && prev_mon && !ext_clk_sel) begin
        if (b2b && have_rise) chk("R6 high phase length", cyc - last_rise, baud_div + 1);
        last_fall = cyc;
        have_fall = 1'b1;
      end
      prev_mon = mon;
    end
  end

  // Driver: write, clear, and queue the expected bits.
  task automatic send(input logic [7:0] b);
    while (!empty_flag) @(negedge clk);
    wr_en = 1'b1; wr_data = b; clr_empty = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; clr_empty = 1'b0;
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 sck_in = 1'b0;
      repeat (8) @(posedge clk);
      #1 sck_in = 1'b1;
      repeat (8) @(posedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 empty flag", empty_flag, 1);
    chk("R1 irq", tx_irq, 0);
    chk("R1 sck", sck_out, 1);
    chk("R1 sdo_oe", sdo_oe, 0);
    chk("R1 sck_oe", sck_oe, 0);

    // Loading is held off while disabled; a repeat clear is ignored
    send(8'hB4);
    chk("R2 flag cleared", empty_flag, 0);
    repeat (30) @(negedge clk);
    chk("R11 no load while disabled", empty_flag, 0);
    chk("R11 data pin undriven", sdo_oe, 0);
    clr_empty = 1'b1;
    @(negedge clk);
    clr_empty = 1'b0;
    chk("R2 clear while 0 ignored", empty_flag, 0);
    tx_en = 1'b1;
    @(negedge clk);
    chk("R11 data pin driven", sdo_oe, 1);
    wait_idle();
    repeat (80) @(negedge clk);
    chk("R3 flag set after move", empty_flag, 1);
    chk("R7 data holds last bit", sdo, 1);
    chk("R7 clock stopped high", sck_out, 1);
    chk("R7 clock pin driven", sck_oe, 1);

    // Back-to-back bytes, divider 2
    have_rise = 1'b0; have_fall = 1'b0; b2b = 1'b1;
    send(8'hA5);
    send(8'h3C);
    send(8'h81);
    wait_idle();
    b2b = 1'b0;
    chk("R3 flag after burst", empty_flag, 1);

    // Divider 0, last bit 0
    baud_div = 8'd0;
    have_rise = 1'b0; have_fall = 1'b0; b2b = 1'b1;
    send(8'h5A);
    @(negedge clk);
    chk("R3 flag set on move from idle", empty_flag, 1);
    send(8'h6E);
    wait_idle();
    b2b = 1'b0;
    chk("R7 data holds last bit 0", sdo, 0);

    // Interrupt level
    baud_div = 8'd2;
    irq_en = 1'b1;
    @(negedge clk);
    chk("R10 irq with empty and enable", tx_irq, 1);
    send(8'hF0);
    chk("R10 irq drops with flag", tx_irq, 0);
    @(negedge clk);
    chk("R10 irq on move", tx_irq, 1);
    wait_idle();
    irq_en = 1'b0;
    @(negedge clk);
    chk("R10 irq off when disabled", tx_irq, 0);

    // External clock
    ext_clk_sel = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 clock pin released", sck_oe, 0);
    chk("R8 internal clock quiet", sck_out, 1);
    send(8'h4B);
    repeat (6) @(negedge clk);
    chk("R8 no advance without pulse", sdo, 1);
    ext_pulses(8);
    @(negedge clk);
    chk("R4 all external bits sent", exp_q.size(), 0);
    chk("R3 flag set in external mode", empty_flag, 1);
    ext_pulses(3);
    repeat (6) @(negedge clk);
    chk("R9 data still last bit", sdo, 0);

    finish_run();
  end
endmodule